// File: doc/BRIEF.md
# Frame Length Class Statistics Counters

This block keeps RMON-style length-class counts for one direction of Ethernet traffic. Each completed frame is reported by a one-cycle event that carries its byte length and an error flag. The length counts the CRC and leaves out preamble and SFD. The block sorts the frame into four classes and advances one 36-bit counter for each class the frame falls in. The classes are: shorter than 64 bytes, longer than a programmable maximum, exactly 64 bytes, and 65 to 127 bytes.

Software reads the counters through a small synchronous read port. Each counter takes two word offsets: the low word comes first, and the upper bits follow at the next offset. Reading the low word also captures that counter's upper bits in a shadow register. A later read of the upper word returns this captured value, so a pair of reads always gives one consistent 36-bit value. A synchronous clear input zeroes every counter and every shadow.

Top module: `frame_size_stats`

## Requirements
- R1: After reset, every mapped offset reads as zero.
- R2: A frame event with length below 64 increments the undersize counter (index 0).
- R3: A frame event with length greater than `max_len_i` increments the oversize counter (index 1). A length equal to `max_len_i` does not count as oversize.
- R4: A frame event with length exactly 64 increments the 64-byte counter (index 2). At most one of the undersize, 64-byte and 65–127 classes matches any frame.
- R5: A frame event with length from 65 to 127 inclusive increments the 65–127 counter (index 3).
- R6: The error flag has no effect: errored frames are classified and counted exactly like good ones.
- R7: Frame events may arrive on every clock. All counters that match an event advance in that cycle, so back-to-back events are never lost. A frame can fall in two classes (for example, 64 bytes with a maximum below 64) and then advances both counters.
- R8: Counter k is read at offset 2k, which returns bits [31:0], and at offset 2k+1, which returns bits [35:32] zero-extended. `rd_data_o` shows the result on the clock edge that samples `rd_en_i`.
- R9: A read of offset 2k latches counter k's upper bits into a shadow. A read of offset 2k+1 returns that shadow even if the counter has moved since.
- R10: `clr_i` zeroes all counters and shadows at the next edge. It takes priority over a frame event in the same cycle.
- R11: Reads of offsets 8 and above return zero.
- R12: A read in the same cycle as an increment of the same counter returns the value from before the increment.
- R13: A counter that holds its all-ones value wraps to zero on the next increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Synchronous clear of all counters and shadows |
| max_len_i | input | 16 | Programmable maximum frame length in bytes |
| evt_valid_i | input | 1 | Frame-end event strobe |
| evt_len_i | input | 16 | Frame length in bytes, CRC included |
| evt_err_i | input | 1 | Frame error flag (does not affect counting) |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 4 | Read word offset |
| rd_data_o | output | 32 | Read data, registered |

## Verification
Two functions can land on the same edge: a frame increment and a software read of that counter, and a clear together with a frame event. The bench raises a 64-byte event and a low-word read of the 64-byte counter at one clock edge. It expects the pre-increment value, then the incremented value on a later read. It also raises `clr_i` and a frame event together and expects zero from every offset afterwards. A narrow-parameter instance pushes its counter past the low-word boundary between the low and high reads, which shows that the shadow holds; that instance also runs the counter through a wrap.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int NUM_BUCKETS = 4;
  localparam int MIN_FRAME   = 64;
  localparam int SMALL_TOP   = 127;

  typedef enum logic [1:0] {
    BKT_UNDER  = 2'd0,
    BKT_OVER   = 2'd1,
    BKT_EQ64   = 2'd2,
    BKT_65_127 = 2'd3
  } bucket_e;
endpackage

// File: rtl/fss_rst_sync.sv
module fss_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fss_classifier.sv
module fss_classifier
  import fss_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                   evt_valid_i,
  input  logic [LEN_W-1:0]       evt_len_i,
  input  logic [LEN_W-1:0]       max_len_i,
  output logic [NUM_BUCKETS-1:0] hit_o
);
  localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_FRAME);
  localparam logic [LEN_W-1:0] TOP_L  = LEN_W'(SMALL_TOP);

  logic [NUM_BUCKETS-1:0] class_w;

  always_comb begin
    class_w             = '0;
    class_w[BKT_UNDER]  = (evt_len_i <  MIN_L);
    class_w[BKT_OVER]   = (evt_len_i >  max_len_i);
    class_w[BKT_EQ64]   = (evt_len_i == MIN_L);
    class_w[BKT_65_127] = (evt_len_i >  MIN_L) && (evt_len_i <= TOP_L);
  end

  assign hit_o = class_w & {NUM_BUCKETS{evt_valid_i}};
endmodule

// File: rtl/fss_counter.sv
module fss_counter #(
  parameter int CNT_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));

  p_wrap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && (&cnt_o)) |=> (cnt_o == '0));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/fss_regport.sv
module fss_regport #(
  parameter int NUM    = 4,
  parameter int CNT_W  = 36,
  parameter int LO_W   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      rd_en_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  input  logic [NUM-1:0][CNT_W-1:0] cnt_i,
  output logic [DATA_W-1:0]         rd_data_o
);
  localparam int HI_W  = CNT_W - LO_W;
  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0]           idx;
  logic                       hi_sel;
  logic                       mapped;
  logic [CNT_W-1:0]           cnt_sel;
  logic [HI_W-1:0]            shd_sel;
  logic [NUM-1:0][HI_W-1:0]   shd_q, shd_d;
  logic [NUM-1:0]             shd_en;
  logic [DATA_W-1:0]          rd_d;

  assign idx    = rd_addr_i[ADDR_W-1:1];
  assign hi_sel = rd_addr_i[0];

  always_comb begin
    mapped  = 1'b0;
    cnt_sel = '0;
    shd_sel = '0;
    for (int k = 0; k < NUM; k++) begin
      if (idx == IDX_W'(k)) begin
        mapped  = 1'b1;
        cnt_sel = cnt_i[k];
        shd_sel = shd_q[k];
      end
    end
  end

  genvar k;
  generate
    for (k = 0; k < NUM; k++) begin : g_shadow
      always_comb begin
        shd_en[k] = clr_i | (rd_en_i && !hi_sel && (idx == IDX_W'(k)));
        shd_d[k]  = clr_i ? '0 : cnt_i[k][CNT_W-1:LO_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         shd_q[k] <= '0;
        else if (shd_en[k]) shd_q[k] <= shd_d[k];
      end
    end
  endgenerate

  always_comb begin
    if (!mapped)     rd_d = '0;
    else if (hi_sel) rd_d = DATA_W'(shd_sel);
    else             rd_d = DATA_W'(cnt_sel[LO_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_d;
  end

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && (rd_addr_i >= ADDR_W'(2*NUM))) |=> (rd_data_o == '0));

  p_shadow_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !(rd_en_i && !rd_addr_i[0])) |=> $stable(shd_q));

  p_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/frame_size_stats.sv
module frame_size_stats
  import fss_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 36,
  parameter int LO_W   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [LEN_W-1:0]  max_len_i,
  input  logic              evt_valid_i,
  input  logic [LEN_W-1:0]  evt_len_i,
  input  logic              evt_err_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic                              rst_sync_n;
  logic [NUM_BUCKETS-1:0]            hit;
  logic [NUM_BUCKETS-1:0][CNT_W-1:0] cnt;
  logic                              err_unused;

  assign err_unused = evt_err_i;

  fss_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fss_classifier #(.LEN_W(LEN_W)) u_classifier (
    .evt_valid_i (evt_valid_i),
    .evt_len_i   (evt_len_i),
    .max_len_i   (max_len_i),
    .hit_o       (hit)
  );

  genvar b;
  generate
    for (b = 0; b < NUM_BUCKETS; b++) begin : g_cnt
      fss_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .clr_i (clr_i),
        .inc_i (hit[b]),
        .cnt_o (cnt[b])
      );
    end
  endgenerate

  fss_regport #(
    .NUM    (NUM_BUCKETS),
    .CNT_W  (CNT_W),
    .LO_W   (LO_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regport (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_i     (clr_i),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .cnt_i     (cnt),
    .rd_data_o (rd_data_o)
  );

  p_small_classes_excl_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({hit[BKT_UNDER], hit[BKT_EQ64], hit[BKT_65_127]}));

  p_no_loss_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt_valid_i && !clr_i && (evt_len_i == LEN_W'(MIN_FRAME)))
      |=> (cnt[BKT_EQ64] == $past(cnt[BKT_EQ64]) + 1'b1));

  p_error_ignored_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt_valid_i && evt_err_i && !clr_i && (evt_len_i < LEN_W'(MIN_FRAME)))
      |=> (cnt[BKT_UNDER] != $past(cnt[BKT_UNDER])));
endmodule

// File: tb/frame_size_stats_tb.sv
`timescale 1ns/1ps
module frame_size_stats_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr;
  logic [15:0] max_len;
  logic        evt_valid;
  logic [15:0] evt_len;
  logic        evt_err;
  logic        rd_en;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;

  logic        n_evt_valid;
  logic        n_rd_en;
  logic [3:0]  n_rd_addr;
  logic [31:0] n_rd_data;

  int checks   = 0;
  int failures = 0;
  logic [35:0] ref_cnt [4];
  int          n_ref;

  always #2 clk = ~clk;

  frame_size_stats u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .max_len_i(max_len),
    .evt_valid_i(evt_valid), .evt_len_i(evt_len), .evt_err_i(evt_err),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  frame_size_stats #(.CNT_W(10), .LO_W(8)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .max_len_i(16'd1518),
    .evt_valid_i(n_evt_valid), .evt_len_i(16'd64), .evt_err_i(1'b0),
    .rd_en_i(n_rd_en), .rd_addr_i(n_rd_addr), .rd_data_o(n_rd_data)
  );

  function automatic logic [3:0] classify(input int len, input int mx);
    logic [3:0] m;
    m[0] = (len < 64);
    m[1] = (len > mx);
    m[2] = (len == 64);
    m[3] = (len >= 65) && (len <= 127);
    return m;
  endfunction

  function automatic string tag(input int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic int pick_len(input int mx);
    case ($urandom % 10)
      0: return 63;
      1: return 64;
      2: return 65;
      3: return 127;
      4: return 128;
      5: return mx;
      6: return mx + 1;
      7: return $urandom % 64;
      8: return $urandom % 200;
      default: return $urandom % 2100;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_frame(input int len);
    logic [3:0] m;
    m = classify(len, int'(max_len));
    for (int k = 0; k < 4; k++) if (m[k]) ref_cnt[k] = ref_cnt[k] + 36'd1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic n_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); n_rd_en = 1'b1; n_rd_addr = a;
    @(negedge clk); n_rd_en = 1'b0; d = n_rd_data;
  endtask

  task automatic burst(input int n, input bit err);
    for (int i = 0; i < n; i++) begin
      int len;
      len = pick_len(int'(max_len));
      @(negedge clk);
      evt_valid = 1'b1; evt_len = 16'(len); evt_err = err;
      model_frame(len);
    end
    @(negedge clk); evt_valid = 1'b0; evt_err = 1'b0;
  endtask

  task automatic n_events(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); n_evt_valid = 1'b1; n_ref = (n_ref + 1) % 1024;
    end
    @(negedge clk); n_evt_valid = 1'b0;
  endtask

  task automatic check_all(input string extra);
    logic [31:0] d;
    for (int k = 0; k < 4; k++) begin
      rd(4'(2*k), d);
      check({tag(k), " R8 low ", extra}, 64'(d), 64'(ref_cnt[k][31:0]));
      rd(4'(2*k+1), d);
      check({tag(k), " R8 high ", extra}, 64'(d), 64'(ref_cnt[k][35:32]));
    end
  endtask

  initial begin
    #600000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    rst_n = 1'b0; clr = 1'b0; max_len = 16'd1518;
    evt_valid = 1'b0; evt_len = '0; evt_err = 1'b0;
    rd_en = 1'b0; rd_addr = '0;
    n_evt_valid = 1'b0; n_rd_en = 1'b0; n_rd_addr = '0;
    for (int k = 0; k < 4; k++) ref_cnt[k] = '0;
    n_ref = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), d);
      check("R1 reset value", 64'(d), 64'd0);
    end

    // R2..R5, R7, R8: random back-to-back frames under several maximums
    foreach (ref_cnt[i]) ;
    for (int p = 0; p < 4; p++) begin
      case (p)
        0: max_len = 16'd1518;
        1: max_len = 16'd100;
        2: max_len = 16'd60;
        default: max_len = 16'd2000;
      endcase
      for (int b = 0; b < 5; b++) burst(1 + ($urandom % 12), 1'b0);
      check_all("R7 random phase");
    end

    // R3 boundary: length equal to the maximum is not oversize
    max_len = 16'd200;
    @(negedge clk); evt_valid = 1'b1; evt_len = 16'd200; model_frame(200);
    @(negedge clk); evt_len = 16'd201; model_frame(201);
    @(negedge clk); evt_valid = 1'b0;
    rd(4'd2, d);
    check("R3 max boundary", 64'(d), 64'(ref_cnt[1][31:0]));

    // R6: errored frames are counted alike
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); evt_valid = 1'b1; evt_err = 1'b1;
      evt_len = (i % 2 == 0) ? 16'd64 : 16'd30;
      model_frame(int'(evt_len));
    end
    @(negedge clk); evt_valid = 1'b0; evt_err = 1'b0;
    rd(4'd4, d); check("R6 errored 64-byte", 64'(d), 64'(ref_cnt[2][31:0]));
    rd(4'd0, d); check("R6 errored undersize", 64'(d), 64'(ref_cnt[0][31:0]));

    // R12: read and increment of the same counter in one cycle
    @(negedge clk);
    evt_valid = 1'b1; evt_len = 16'd64; rd_en = 1'b1; rd_addr = 4'd4;
    @(negedge clk);
    evt_valid = 1'b0; rd_en = 1'b0;
    check("R12 pre-increment value", 64'(rd_data), 64'(ref_cnt[2][31:0]));
    model_frame(64);
    rd(4'd4, d); check("R12 post-increment value", 64'(d), 64'(ref_cnt[2][31:0]));

    // R11: unmapped offsets
    rd(4'd8, d);  check("R11 offset 8", 64'(d), 64'd0);
    rd(4'd15, d); check("R11 offset 15", 64'(d), 64'd0);

    // R9: shadow holds upper bits across later increments (narrow instance)
    n_events(300);
    n_rd(4'd4, d); check("R9 narrow low", 64'(d), 64'(n_ref % 256));
    n_events(300);
    n_rd(4'd5, d); check("R9 shadow kept", 64'(d), 64'd1);
    n_rd(4'd4, d); check("R9 narrow low again", 64'(d), 64'(n_ref % 256));
    n_rd(4'd5, d); check("R9 new upper bits", 64'(d), 64'(n_ref / 256));

    // R13: wrap to zero
    n_events(423);
    n_rd(4'd4, d); check("R13 all-ones low", 64'(d), 64'd255);
    n_rd(4'd5, d); check("R13 all-ones high", 64'(d), 64'd3);
    n_events(1);
    n_rd(4'd4, d); check("R13 wrapped low", 64'(d), 64'd0);
    n_rd(4'd5, d); check("R13 wrapped high", 64'(d), 64'd0);

    // R10: clear beats a simultaneous event, shadows cleared
    n_events(300);
    n_rd(4'd4, d);
    @(negedge clk);
    clr = 1'b1; evt_valid = 1'b1; evt_len = 16'd64; n_evt_valid = 1'b1;
    @(negedge clk);
    clr = 1'b0; evt_valid = 1'b0; n_evt_valid = 1'b0;
    for (int k = 0; k < 4; k++) ref_cnt[k] = '0;
    check_all("R10 after clear");
    n_rd(4'd5, d); check("R10 shadow cleared", 64'(d), 64'd0);
    n_rd(4'd4, d); check("R10 narrow cleared", 64'(d), 64'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule